// File: doc/BRIEF.md
# Polarity-Aware Priority Mask

This block is a purely combinational priority filter over a vector of request-like bits, where each bit position has its own fixed active level. A bit is "active" when its value matches the polarity constant for that position, so some lanes are active-high and others active-low. The output keeps the lowest-index active bit exactly as it arrived. Every lane above that bit is forced to its own inactive level. Lanes below the winner are inactive, so they pass through unchanged.

The block is meant to sit inside larger datapaths. Typical uses are picking the first of several mixed-polarity select or request lines, or cleaning a vector so that at most one lane looks active. There is no clock, enable or reset, so the output follows the input combinationally. Two build-time variants of the "any earlier lane active" chain are available: a linear ripple and a logarithmic-depth prefix tree. Both produce identical outputs. A width of zero is accepted and yields a tied-off placeholder output.

Top module: `polarity_priority_mask`

## Requirements
- R1: Lane i counts as active exactly when input bit i equals bit i of the `POLARITY` parameter (1 means active-high, 0 means active-low).
- R2: Output bit 0 always equals input bit 0, for every input value and every polarity.
- R3: For each lane i of 1 or more, when any lane with a lower index is active, output bit i equals the complement of `POLARITY[i]`.
- R4: For each lane i of 1 or more, when no lower-index lane is active, output bit i equals input bit i.
- R5: The output has at most one lane at its active level. When any input lane is active, the only active output lane is the lowest-index active input lane.
- R6: When no input lane is active, the output equals the input.
- R7: With `WIDTH` set to 0 the block elaborates, contains no mask logic, and drives its 1-bit placeholder output to 0.
- R8: The ripple chain (`CHAIN_STYLE` = `PM_CHAIN_RIPPLE`) and the prefix-tree chain (`CHAIN_STYLE` = `PM_CHAIN_PREFIX`) give identical outputs for every input and polarity.
- R9: The block holds no state. The output follows a change of input without any clock edge, and it depends only on the present input.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_in | input | WIDTH (1 when WIDTH is 0) | Raw lane vector; each lane judged against its own polarity bit |
| y_out | output | WIDTH (1 when WIDTH is 0) | Masked vector: first active lane kept, later lanes forced inactive |

## Verification
The hardest case to reach is a mixed-polarity vector in which several lanes are active and some inactive lanes sit below the winner. In that case the output must keep the lower inactive lanes, keep the winner, and drive the upper lanes to a level that is 1 on some lanes and 0 on others. The bench reaches it by sweeping every input pattern for widths 1 to 6. It does this under all-ones, all-zeros and both alternating polarity masks, and also on an 8-bit instance with an irregular mask. Each result is compared with a behavioural loop. The same sweep runs the ripple and prefix variants side by side, so that any difference between them shows up.

// File: rtl/pm_pkg.sv
// Package: shared types for the polarity-aware priority mask.
// Assumes: nothing; holds only the variant selector for the chain.
package pm_pkg;

    // Structure of the "any lower lane active" chain.
    typedef enum logic {
        PM_CHAIN_RIPPLE = 1'b0,
        PM_CHAIN_PREFIX = 1'b1
    } pm_chain_style_e;

endpackage

// File: rtl/pm_level_detect.sv
// Module: pm_level_detect
// Turns each raw lane into an "active" flag by comparing it with that
// lane's polarity bit. The polarity is a constant, so each lane reduces
// to a wire or an inverter.
// Assumes: W >= 1.
module pm_level_detect #(
    parameter int           W   = 8,
    parameter logic [W-1:0] POL = '1
) (
    input  logic [W-1:0] lane_raw,
    output logic [W-1:0] lane_act
);

    // Per lane, choose a buffer or an inverter according to the polarity bit.
    for (genvar gi = 0; gi < W; gi++) begin : g_lane
        if (POL[gi]) begin : g_high
            assign lane_act[gi] = lane_raw[gi];
        end else begin : g_low
            assign lane_act[gi] = ~lane_raw[gi];
        end
    end

endmodule

// File: rtl/pm_prefix_chain.sv
// Module: pm_prefix_chain
// Forms seen[i] = OR of act[0..i]. A parameter selects a linear ripple
// (W-1 OR gates in series) or a log-depth prefix tree.
// Assumes: W >= 1.
module pm_prefix_chain
    import pm_pkg::*;
#(
    parameter int              W     = 8,
    parameter pm_chain_style_e STYLE = PM_CHAIN_RIPPLE
) (
    input  logic [W-1:0] act,
    output logic [W-1:0] seen
);

    localparam int LVL = (W > 1) ? $clog2(W) : 0;

    if (STYLE == PM_CHAIN_RIPPLE) begin : g_ripple
        // Running OR from lane 0 upward, one gate per lane.
        assign seen[0] = act[0];
        for (genvar gi = 1; gi < W; gi++) begin : g_step
            assign seen[gi] = seen[gi-1] | act[gi];
        end
    end else begin : g_prefix
        logic [W-1:0] stage [LVL+1];
        assign stage[0] = act;
        // Each level folds in the partial OR from 2**l lanes below.
        for (genvar gl = 0; gl < LVL; gl++) begin : g_lvl
            for (genvar gi = 0; gi < W; gi++) begin : g_bit
                if (gi >= (1 << gl)) begin : g_merge
                    assign stage[gl+1][gi] = stage[gl][gi] | stage[gl][gi-(1<<gl)];
                end else begin : g_keep
                    assign stage[gl+1][gi] = stage[gl][gi];
                end
            end
        end
        assign seen = stage[LVL];
    end

endmodule

// File: rtl/pm_output_select.sv
// Module: pm_output_select
// Builds the masked vector. Lane 0 passes straight through. A higher lane
// passes its raw value unless some lower lane was active, in which case it
// is driven to its own inactive level.
// Assumes: W >= 1; seen[i] is the OR of the activity of lanes 0..i.
module pm_output_select #(
    parameter int           W   = 8,
    parameter logic [W-1:0] POL = '1
) (
    input  logic [W-1:0] lane_raw,
    input  logic [W-1:0] seen,
    output logic [W-1:0] lane_out
);

    // Lane 0 has nothing ahead of it in priority.
    assign lane_out[0] = lane_raw[0];

    // Higher lanes: pass through or force to the inactive level.
    for (genvar gi = 1; gi < W; gi++) begin : g_lane
        assign lane_out[gi] = seen[gi-1] ? ~POL[gi] : lane_raw[gi];
    end

endmodule

// File: rtl/polarity_priority_mask.sv
// Module: polarity_priority_mask (top)
// Keeps the lowest-index active lane of a_in, where each lane's active
// level is set by POLARITY, and forces every later lane inactive.
// Purely combinational: no clock, no reset, no storage.
// Assumes: POLARITY is a build-time constant. WIDTH may be 0, in which
// case the 1-bit placeholder output is tied to 0.
module polarity_priority_mask
    import pm_pkg::*;
#(
    parameter int                                    WIDTH       = 8,
    parameter logic [((WIDTH > 0) ? WIDTH : 1)-1:0]  POLARITY    = '1,
    parameter pm_chain_style_e                       CHAIN_STYLE = PM_CHAIN_RIPPLE
) (
    input  logic [((WIDTH > 0) ? WIDTH : 1)-1:0] a_in,
    output logic [((WIDTH > 0) ? WIDTH : 1)-1:0] y_out
);

    localparam int PW = (WIDTH > 0) ? WIDTH : 1;

    if (WIDTH == 0) begin : g_empty
        // No lanes: placeholder output is a constant.
        assign y_out = '0;
    end else begin : g_mask
        logic [PW-1:0] act_in;
        logic [PW-1:0] seen;
        logic [PW-1:0] act_out;

        pm_level_detect #(.W(PW), .POL(POLARITY)) u_detect (
            .lane_raw (a_in),
            .lane_act (act_in)
        );

        pm_prefix_chain #(.W(PW), .STYLE(CHAIN_STYLE)) u_chain (
            .act  (act_in),
            .seen (seen)
        );

        pm_output_select #(.W(PW), .POL(POLARITY)) u_select (
            .lane_raw (a_in),
            .seen     (seen),
            .lane_out (y_out)
        );

        // Activity of the output lanes, used only by the checks below.
        assign act_out = ~(y_out ^ POLARITY);

        // Checks on the settled relation between input and output.
        always_comb begin
            AST_LANE0_PASS: assert (y_out[0] == a_in[0]) else $error("lane 0 altered"); // R2
            AST_ONE_ACTIVE: assert ($countones(act_out) <= 1) else $error("several active outputs"); // R5
            AST_NO_NEW_ACTIVE: assert ((act_out & ~act_in) == '0) else $error("output active where input was not"); // R3
            AST_WINNER_KEPT: assert ((act_in == '0) || (act_out != '0)) else $error("active input lost"); // R5
            AST_IDLE_PASS: assert ((act_in != '0) || (y_out == a_in)) else $error("idle vector altered"); // R6
        end
    end

endmodule

// File: tb/polarity_priority_mask_bench.sv
// Directed bench: exhaustive sweeps of small widths under several polarity
// masks, for both chain variants, compared with a behavioural loop.
module polarity_priority_mask_bench;
    import pm_pkg::*;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2 clk = ~clk; // 250 MHz

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 1'b0;

    localparam logic [7:0] MAIN_POL = 8'b0110_1001;

    // Polarity mask index p for a grid instance of width w.
    function automatic logic [5:0] pol_of(int w, int p);
        logic [5:0] m;
        case (p)
            0: m = 6'b111111;
            1: m = 6'b000000;
            2: m = 6'b010101;
            default: m = 6'b101010;
        endcase
        return m & 6'((7'd1 << w) - 7'd1);
    endfunction

    // Behavioural reference: walk lanes upward.
    function automatic logic [7:0] ref_mask(logic [7:0] a, logic [7:0] pol, int w);
        logic [7:0] y = '0;
        bit found = 1'b0;
        for (int i = 0; i < w; i++) begin
            y[i] = found ? ~pol[i] : a[i];
            if (a[i] == pol[i]) found = 1'b1;
        end
        return y;
    endfunction

    logic [7:0] stim8 = '0;
    logic [7:0] y8;
    logic [5:0] stim6 = '0;
    logic [5:0] y_rip [24];
    logic [5:0] y_pfx [24];
    logic       z_in = 1'b1;
    logic       z_out;

    polarity_priority_mask #(.WIDTH(8), .POLARITY(MAIN_POL), .CHAIN_STYLE(PM_CHAIN_RIPPLE))
        u_polarity_priority_mask (.a_in(stim8), .y_out(y8));

    polarity_priority_mask #(.WIDTH(0)) u_zero (.a_in(z_in), .y_out(z_out));

    for (genvar gw = 1; gw <= 6; gw++) begin : g_w
        for (genvar gp = 0; gp < 4; gp++) begin : g_p
            localparam logic [5:0] P6 = pol_of(gw, gp);
            logic [gw-1:0] yr, yp;
            polarity_priority_mask #(.WIDTH(gw), .POLARITY(P6[gw-1:0]), .CHAIN_STYLE(PM_CHAIN_RIPPLE))
                u_rip (.a_in(stim6[gw-1:0]), .y_out(yr));
            polarity_priority_mask #(.WIDTH(gw), .POLARITY(P6[gw-1:0]), .CHAIN_STYLE(PM_CHAIN_PREFIX))
                u_pfx (.a_in(stim6[gw-1:0]), .y_out(yp));
            assign y_rip[(gw-1)*4+gp] = 6'(yr);
            assign y_pfx[(gw-1)*4+gp] = 6'(yp);
        end
    end

    task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%b expected=%b", req, act, exp);
        end
    endtask

    // Initial state: all-zero input on the 8-bit instance.
    task automatic t_initial();
        @(negedge clk); stim8 = '0; #1;
        chk("R1 initial", y8, ref_mask(8'h00, MAIN_POL, 8));
    endtask

    // R1/R3/R4: full sweep of widths 1..6, four masks, ripple variant.
    task automatic t_grid_sweep();
        for (int v = 0; v < 64; v++) begin
            @(negedge clk); stim6 = 6'(v); #1;
            for (int w = 1; w <= 6; w++)
                for (int p = 0; p < 4; p++)
                    chk("R1 R3 R4 grid", 8'(y_rip[(w-1)*4+p]),
                        ref_mask(8'(stim6), 8'(pol_of(w, p)), w));
        end
    endtask

    // R8: prefix variant must match the reference and the ripple output.
    task automatic t_styles();
        for (int v = 0; v < 64; v++) begin
            @(negedge clk); stim6 = 6'(v); #1;
            for (int k = 0; k < 24; k++)
                chk("R8 variants", 8'(y_pfx[k]), 8'(y_rip[k]));
        end
    endtask

    // R2/R5/R3/R4: all 256 patterns on the irregular 8-bit mask.
    task automatic t_main_sweep();
        for (int v = 0; v < 256; v++) begin
            logic [7:0] act_in, act_out, lowest;
            @(negedge clk); stim8 = 8'(v); #1;
            chk("R2 lane0", 8'(y8[0]), 8'(stim8[0]));
            chk("R3 R4 main", y8, ref_mask(stim8, MAIN_POL, 8));
            act_in  = ~(stim8 ^ MAIN_POL);
            act_out = ~(y8 ^ MAIN_POL);
            lowest  = act_in & (~act_in + 8'd1);
            chk("R5 single winner", act_out, lowest);
        end
    endtask

    // R6: no active lane, output equals input.
    task automatic t_idle();
        @(negedge clk); stim8 = ~MAIN_POL; #1;
        chk("R6 idle 8", y8, ~MAIN_POL);
        @(negedge clk); stim6 = 6'b000000; #1;
        chk("R6 idle grid high", 8'(y_rip[5*4+0]), 8'h00);
        @(negedge clk); stim6 = 6'b111111; #1;
        chk("R6 idle grid low", 8'(y_rip[5*4+1]), 8'h3F);
    endtask

    // R7: zero-width instance drives constant 0.
    task automatic t_zero();
        @(negedge clk); z_in = 1'b1; #1;
        chk("R7 zero width", 8'(z_out), 8'h00);
        z_in = 1'b0; #1;
        chk("R7 zero width", 8'(z_out), 8'h00);
    endtask

    // R9: output follows the input without a clock edge, and does not remember earlier inputs.
    task automatic t_comb();
        @(posedge clk); #0.5;
        stim8 = 8'b1111_1111; #0.5;
        chk("R9 follow", y8, ref_mask(8'hFF, MAIN_POL, 8));
        stim8 = 8'b0000_0000; #0.5;
        chk("R9 follow", y8, ref_mask(8'h00, MAIN_POL, 8));
        stim8 = 8'b1001_0110; #0.5;
        chk("R9 no memory", y8, 8'b1001_0110);
    endtask

    initial begin
        repeat (2) @(posedge clk);
        rst_n = 1'b1;
        t_initial();
        t_grid_sweep();
        t_styles();
        t_main_sweep();
        t_idle();
        t_zero();
        t_comb();
        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
            $finish;
        end
    end

endmodule